// File: doc/BRIEF.md
# Page-Translating DMA Channel

This block is a single DMA channel that moves a run of bytes between a device byte stream and a memory master port. Software sees the run as a range of logical addresses. Each logical 4 KB page is mapped to a physical page frame by a 32-bit entry in a page table held in memory. Entries sit eight bytes apart, starting at a programmable table base.

Software first programs the table base, a mode word, an enable word, a byte count and a starting logical address. It then raises a one-cycle start request that carries the transfer direction. The channel checks the request against the enable word and either rejects it or runs the transfer. During a transfer it fetches a page-table entry each time the logical address enters a page it has not yet mapped. It moves one byte per step through the translated address. When it finishes, it clears the byte count and gives a one-cycle done pulse. A configuration input selects whether a fetched entry is assembled big-endian or little-endian.

Top module: `ptdma_channel`

## Requirements
- R1: Five registers are written and read back unchanged through `reg_addr_i`: mode at 0x00, enable at 0x08, byte count at 0x10, logical start address at 0x18 and table base at 0x20. All of them read zero after reset, and any other offset reads zero.
- R2: Enable bit 0 is run and enable bit 1 is direction (1 means memory-to-device, 0 means device-to-memory). A start is rejected in two cases: run is clear, or `start_to_mem_i` equals the direction bit. A rejected start pulses `reject_o` for one cycle, issues no memory request, moves no byte and leaves the count register unchanged.
- R3: A table entry is fetched as a 4-byte read (`mem_req_word_o`=1) at table base + (logical address >> 12) * 8.
- R4: In a 4-byte read response, `mem_rsp_data_i[7:0]` is the byte at the lowest address. When `big_endian_i`=1 that byte is the most significant byte of the entry; when it is 0 that byte is the least significant byte.
- R5: Each data byte is accessed as a single-byte request (`mem_req_word_o`=0) at (entry with its low 12 bits cleared) + (logical address bits 11:0). A byte read returns its data in `mem_rsp_data_i[7:0]`.
- R6: A transfer moves exactly count bytes, in increasing logical address order, starting at the programmed logical address.
- R7: An entry is fetched once for each 4 KB logical page the transfer touches. The fetch happens when the transfer enters the page, and no other fetches are made.
- R8: In memory-to-device mode each byte is read from memory and then presented on `dev_out`. In device-to-memory mode each byte is taken from `dev_in` and then written to memory.
- R9: When all bytes have been moved, the count register reads zero, `done_o` pulses for one cycle and `busy_o` goes low.
- R10: A start with a count of zero completes with a done pulse and issues no memory request.
- R11: If software clears the run bit during a transfer, the byte in progress completes, the channel then stops with a done pulse, and the count register keeps its programmed value.
- R12: On `mem_req` and `dev_out`, a raised valid stays high with a stable payload until ready is seen. No request or stream valid is raised while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian_i | input | 1 | Byte order used to assemble a table entry |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data at `reg_addr_i` |
| start_i | input | 1 | One-cycle start request |
| start_to_mem_i | input | 1 | Requested direction: 1 = device-to-memory |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| reject_o | output | 1 | One-cycle pulse when a start is refused |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_word_o | output | 1 | 1 = 4-byte read (table entry), 0 = one byte |
| mem_req_addr_o | output | 32 | Physical request address |
| mem_req_wdata_o | output | 8 | Write byte |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data, lowest-address byte in bits 7:0 |
| dev_out_valid_o | output | 1 | Byte to device valid |
| dev_out_ready_i | input | 1 | Device accepts byte |
| dev_out_data_o | output | 8 | Byte to device |
| dev_in_valid_i | input | 1 | Byte from device valid |
| dev_in_ready_o | output | 1 | Channel accepts byte |
| dev_in_data_i | input | 8 | Byte from device |

## Verification
The central sweep varies the start address over the last six bytes of a page and the count from one to eight. This separates transfers that stay inside one page from transfers that cross into the next, so both an off-by-one in the end test and a missing or extra table fetch show up. The two pages map to frames far apart, and the entries carry junk in their low bits, so a wrong frame or an unmasked entry gives visibly wrong bytes. The same mapping is also stored big-endian, where a byte-order error sends reads to the wrong frame. Separate runs cover device-to-memory writes, rejected starts in both mismatch forms, a zero count, and a run-bit clear while a byte is stalled on the device side. The stop test tells "finish the current byte" apart from both aborting at once and running to the end.

// File: rtl/ptdma_pkg.sv
package ptdma_pkg;

    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned PAGE_BITS   = 12;
    localparam int unsigned STRIDE_LOG2 = 3;

    // register slots, selected by reg_addr[5:3]
    localparam int unsigned REG_MODE   = 0;
    localparam int unsigned REG_ENABLE = 1;
    localparam int unsigned REG_COUNT  = 2;
    localparam int unsigned REG_LADDR  = 3;
    localparam int unsigned REG_TBASE  = 4;
    localparam int unsigned NUM_REGS   = 5;

    localparam int unsigned EN_RUN_BIT = 0;
    localparam int unsigned EN_DIR_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NEXT,
        ST_TBL_REQ,
        ST_TBL_RSP,
        ST_DEV_IN,
        ST_MEM_REQ,
        ST_MEM_RSP,
        ST_DEV_OUT
    } chan_state_e;

    // the lowest-address byte arrives in bits 7:0
    function automatic logic [31:0] order_entry(input logic [31:0] raw, input logic big);
        return big ? {raw[7:0], raw[15:8], raw[23:16], raw[31:24]} : raw;
    endfunction

endpackage

// File: rtl/ptdma_regs.sv
module ptdma_regs #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = ptdma_pkg::NUM_REGS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [5:0]               addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     clr_count,
    output logic [NREG-1:0][DW-1:0]  bank_o,
    output logic [DW-1:0]            rdata
);
    localparam int unsigned IDX_W = 3;

    logic [IDX_W-1:0] idx;
    logic             slot_ok;

    assign idx     = addr[5:3];
    assign slot_ok = (addr[2:0] == 3'b000) && (32'(idx) < NREG);

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_o[i] <= '0;
            end else if (i == ptdma_pkg::REG_COUNT && clr_count) begin
                bank_o[i] <= '0;
            end else if (we && slot_ok && 32'(idx) == i) begin
                bank_o[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NREG; k++) begin
            if (slot_ok && 32'(idx) == k) rdata = bank_o[k];
        end
    end
endmodule

// File: rtl/ptdma_pager.sv
module ptdma_pager #(
    parameter int unsigned AW          = ptdma_pkg::ADDR_W,
    parameter int unsigned PAGE_BITS   = ptdma_pkg::PAGE_BITS,
    parameter int unsigned STRIDE_LOG2 = ptdma_pkg::STRIDE_LOG2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          load,
    input  logic          big_endian,
    input  logic [31:0]   rsp_data,
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] tbase,
    output logic          hit,
    output logic [AW-1:0] entry_addr,
    output logic [AW-1:0] phys_addr
);
    localparam int unsigned PN_W = AW - PAGE_BITS;

    logic [PN_W-1:0] frame_q;
    logic [PN_W-1:0] tag_q;
    logic            valid_q;
    logic [31:0]     entry;
    logic [PN_W-1:0] page_no;

    assign page_no = cur_addr[AW-1:PAGE_BITS];
    assign entry   = ptdma_pkg::order_entry(rsp_data, big_endian);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= 1'b0;
            frame_q <= '0;
            tag_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            frame_q <= entry[AW-1:PAGE_BITS];
            tag_q   <= page_no;
        end
    end

    assign hit        = valid_q && (tag_q == page_no);
    assign entry_addr = tbase + (AW'(page_no) << STRIDE_LOG2);
    assign phys_addr  = {frame_q, cur_addr[PAGE_BITS-1:0]};
endmodule

// File: rtl/ptdma_channel.sv
module ptdma_channel
    import ptdma_pkg::*;
#(
    parameter int unsigned AW = ptdma_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          big_endian_i,
    input  logic          reg_we_i,
    input  logic [5:0]    reg_addr_i,
    input  logic [31:0]   reg_wdata_i,
    output logic [31:0]   reg_rdata_o,
    input  logic          start_i,
    input  logic          start_to_mem_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          reject_o,
    output logic          mem_req_valid_o,
    input  logic          mem_req_ready_i,
    output logic          mem_req_write_o,
    output logic          mem_req_word_o,
    output logic [AW-1:0] mem_req_addr_o,
    output logic [7:0]    mem_req_wdata_o,
    input  logic          mem_rsp_valid_i,
    input  logic [31:0]   mem_rsp_data_i,
    output logic          dev_out_valid_o,
    input  logic          dev_out_ready_i,
    output logic [7:0]    dev_out_data_o,
    input  logic          dev_in_valid_i,
    output logic          dev_in_ready_o,
    input  logic [7:0]    dev_in_data_i
);
    logic [NUM_REGS-1:0][31:0] bank;
    chan_state_e state_q;
    logic [AW-1:0] cur_q, end_q;
    logic          to_mem_q;
    logic [7:0]    byte_q;
    logic          done_q, reject_q;
    logic          clr_count, flush, load, hit;
    logic [AW-1:0] entry_addr, phys_addr;
    logic          run, dir_m2d;

    assign run     = bank[REG_ENABLE][EN_RUN_BIT];
    assign dir_m2d = bank[REG_ENABLE][EN_DIR_BIT];

    ptdma_regs #(.DW(32), .NREG(NUM_REGS)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we_i), .addr(reg_addr_i),
        .wdata(reg_wdata_i), .clr_count(clr_count),
        .bank_o(bank), .rdata(reg_rdata_o)
    );

    ptdma_pager #(.AW(AW)) u_pager (
        .clk(clk), .rst(rst), .flush(flush), .load(load),
        .big_endian(big_endian_i), .rsp_data(mem_rsp_data_i),
        .cur_addr(cur_q), .tbase(bank[REG_TBASE][AW-1:0]),
        .hit(hit), .entry_addr(entry_addr), .phys_addr(phys_addr)
    );

    logic accept_start;
    logic finish_now;

    assign accept_start = (state_q == ST_IDLE) && start_i && run && (dir_m2d != start_to_mem_i);
    assign flush        = accept_start;
    assign load         = (state_q == ST_TBL_RSP) && mem_rsp_valid_i;
    assign finish_now   = (state_q == ST_NEXT) && ((cur_q >= end_q) || !run);
    assign clr_count    = (state_q == ST_NEXT) && (cur_q >= end_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            end_q    <= '0;
            to_mem_q <= 1'b0;
            byte_q   <= '0;
            done_q   <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            done_q   <= finish_now;
            reject_q <= (state_q == ST_IDLE) && start_i && !accept_start;
            unique case (state_q)
                ST_IDLE: if (accept_start) begin
                    cur_q    <= bank[REG_LADDR][AW-1:0];
                    end_q    <= bank[REG_LADDR][AW-1:0] + bank[REG_COUNT][AW-1:0];
                    to_mem_q <= start_to_mem_i;
                    state_q  <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (finish_now)   state_q <= ST_IDLE;
                    else if (!hit)    state_q <= ST_TBL_REQ;
                    else if (to_mem_q) state_q <= ST_DEV_IN;
                    else              state_q <= ST_MEM_REQ;
                end
                ST_TBL_REQ: if (mem_req_ready_i) state_q <= ST_TBL_RSP;
                ST_TBL_RSP: if (mem_rsp_valid_i) state_q <= ST_NEXT;
                ST_DEV_IN: if (dev_in_valid_i) begin
                    byte_q  <= dev_in_data_i;
                    state_q <= ST_MEM_REQ;
                end
                ST_MEM_REQ: if (mem_req_ready_i) begin
                    if (to_mem_q) begin
                        cur_q   <= cur_q + 1'b1;
                        state_q <= ST_NEXT;
                    end else begin
                        state_q <= ST_MEM_RSP;
                    end
                end
                ST_MEM_RSP: if (mem_rsp_valid_i) begin
                    byte_q  <= mem_rsp_data_i[7:0];
                    state_q <= ST_DEV_OUT;
                end
                ST_DEV_OUT: if (dev_out_ready_i) begin
                    cur_q   <= cur_q + 1'b1;
                    state_q <= ST_NEXT;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_valid_o = 1'b0;
        mem_req_write_o = 1'b0;
        mem_req_word_o  = 1'b0;
        mem_req_addr_o  = phys_addr;
        if (state_q == ST_TBL_REQ) begin
            mem_req_valid_o = 1'b1;
            mem_req_word_o  = 1'b1;
            mem_req_addr_o  = entry_addr;
        end else if (state_q == ST_MEM_REQ) begin
            mem_req_valid_o = 1'b1;
            mem_req_write_o = to_mem_q;
        end
    end

    assign mem_req_wdata_o = byte_q;
    assign dev_out_valid_o = (state_q == ST_DEV_OUT);
    assign dev_out_data_o  = byte_q;
    assign dev_in_ready_o  = (state_q == ST_DEV_IN);
    assign busy_o          = (state_q != ST_IDLE);
    assign done_o          = done_q;
    assign reject_o        = reject_q;
endmodule

// File: rtl/ptdma_channel_checker.sv
module ptdma_channel_checker #(
    parameter int unsigned AW = ptdma_pkg::ADDR_W
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          reject,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_write,
    input logic          mem_word,
    input logic          dout_valid,
    input logic          dout_ready,
    input logic [7:0]    dout_data,
    input logic          din_ready,
    input logic [AW-1:0] cur,
    input logic [AW-1:0] last
);
    // R12: nothing is requested while idle
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_valid && !dout_valid && !din_ready));

    // R12: memory request held until accepted
    p_mem_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_write) && $stable(mem_word)));

    // R12: device byte held until accepted
    p_dout_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

    // R9: done leaves the channel idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2: a rejected start never starts a transfer
    p_reject_idle_r2: assert property (@(posedge clk) disable iff (rst)
        reject |-> (!busy && !done));

    // R6: the logical pointer never runs past the end of the range
    p_cur_range_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cur <= last));
endmodule

bind ptdma_channel ptdma_channel_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy_o), .done(done_o), .reject(reject_o),
    .mem_valid(mem_req_valid_o), .mem_ready(mem_req_ready_i),
    .mem_addr(mem_req_addr_o), .mem_write(mem_req_write_o),
    .mem_word(mem_req_word_o), .dout_valid(dev_out_valid_o),
    .dout_ready(dev_out_ready_i), .dout_data(dev_out_data_o),
    .din_ready(dev_in_ready_o), .cur(cur_q), .last(end_q)
);

// File: tb/ptdma_channel_test.sv
module ptdma_channel_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        big_endian = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        start = 1'b0, start_to_mem = 1'b0;
    logic        busy, done, reject;
    logic        mvalid, mwrite, mword;
    logic        mready = 1'b1;
    logic [31:0] maddr;
    logic [7:0]  mwdata;
    logic        rvalid = 1'b0;
    logic [31:0] rdata = '0;
    logic        dout_valid, din_ready;
    logic        sink_ready = 1'b1;
    logic [7:0]  dout_data;
    logic [7:0]  din_data;

    ptdma_channel uut (
        .clk(clk), .rst(rst), .big_endian_i(big_endian),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .start_i(start), .start_to_mem_i(start_to_mem),
        .busy_o(busy), .done_o(done), .reject_o(reject),
        .mem_req_valid_o(mvalid), .mem_req_ready_i(mready), .mem_req_write_o(mwrite),
        .mem_req_word_o(mword), .mem_req_addr_o(maddr), .mem_req_wdata_o(mwdata),
        .mem_rsp_valid_i(rvalid), .mem_rsp_data_i(rdata),
        .dev_out_valid_o(dout_valid), .dev_out_ready_i(sink_ready), .dev_out_data_o(dout_data),
        .dev_in_valid_i(1'b1), .dev_in_ready_o(din_ready), .dev_in_data_i(din_data)
    );

    // bench memory, device source and sink; counters only ever grow
    logic [7:0]  mem [0:8191];
    logic [7:0]  got [0:1023];
    int          n_got = 0, n_fetch = 0, n_byteop = 0, n_done = 0, n_rej = 0, n_src = 0;
    logic        pl_we = 1'b0;
    logic [12:0] pl_addr = '0;
    logic [7:0]  pl_data = '0;

    assign din_data = 8'hA0 + 8'(n_src);

    always @(posedge clk) begin
        mready <= ~mready;
        rvalid <= 1'b0;
        if (pl_we) mem[pl_addr] <= pl_data;
        if (mvalid && mready) begin
            if (mword) n_fetch <= n_fetch + 1;
            else       n_byteop <= n_byteop + 1;
            if (mwrite) mem[maddr[12:0]] <= mwdata;
            else begin
                rvalid <= 1'b1;
                rdata  <= {mem[maddr[12:0] + 13'd3], mem[maddr[12:0] + 13'd2],
                           mem[maddr[12:0] + 13'd1], mem[maddr[12:0]]};
            end
        end
        if (dout_valid && sink_ready) begin
            got[n_got[9:0]] <= dout_data;
            n_got <= n_got + 1;
        end
        if (din_ready) n_src <= n_src + 1;
        if (done)   n_done <= n_done + 1;
        if (reject) n_rej <= n_rej + 1;
    end

    int errors = 0, checks = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic poke(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic poke_entry(input logic [12:0] a, input logic [31:0] e, input logic big);
        for (int b = 0; b < 4; b++)
            poke(a + 13'(b), big ? e[8*(3-b) +: 8] : e[8*b +: 8]);
    endtask

    task automatic go(input logic to_mem);
        @(negedge clk);
        start = 1'b1; start_to_mem = to_mem;
        @(negedge clk);
        start = 1'b0;
    endtask

    // bounded wait: a hang counts as a failed check
    task automatic wait_done(input int d0, input string req);
        int guard = 0;
        while (n_done == d0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        if (n_done == d0) check(req, "watchdog, no done", 0, 1);
    endtask

    function automatic logic [12:0] phys_of(input int la);
        // page 0 -> frame 0x1000, page 1 -> frame 0x0000
        return ((la >> 12) == 0) ? 13'(32'h1000 + (la & 32'hFFF)) : 13'(la & 32'hFFF);
    endfunction

    function automatic logic [7:0] pat(input logic [12:0] p);
        return p[7:0] ^ 8'h5A;
    endfunction

    task automatic to_dev_run(input int la, input int cnt, input string tag);
        int g0, f0, d0;
        logic [31:0] v;
        wr(6'h18, la);
        wr(6'h10, cnt);
        g0 = n_got; f0 = n_fetch; d0 = n_done;
        go(1'b0);
        wait_done(d0, "R9");
        @(negedge clk);
        check("R6", {tag, " byte total"}, n_got - g0, cnt);
        for (int i = 0; i < cnt; i++)
            check("R5", {tag, " byte"}, got[10'(g0 + i)], pat(phys_of(la + i)));
        check("R7", {tag, " table fetches"}, n_fetch - f0, ((la + cnt - 1) >> 12) - (la >> 12) + 1);
        rd(6'h10, v);
        check("R9", {tag, " count cleared"}, v, 0);
    endtask

    initial begin
        logic [31:0] v;
        int f0, b0, d0, r0, g0;
        for (int i = 0; i < 8192; i++) mem[i] = pat(13'(i));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and readback
        for (int r = 0; r < 5; r++) begin
            rd(6'(r * 8), v);
            check("R1", "reset value", v, 0);
        end
        check("R9", "idle after reset", busy, 0);
        for (int r = 0; r < 5; r++) wr(6'(r * 8), 32'h1234_5600 + 32'(r));
        for (int r = 0; r < 5; r++) begin
            rd(6'(r * 8), v);
            check("R1", "readback", v, 32'h1234_5600 + 32'(r));
        end
        rd(6'h04, v);
        check("R1", "unmapped offset", v, 0);

        // table at 0x100: page 0 -> 0x1000, page 1 -> 0x0000, junk low bits
        wr(6'h20, 32'h100);
        wr(6'h00, 32'h0);
        poke_entry(13'h100, 32'h0000_1ABC, 1'b0);
        poke_entry(13'h108, 32'h0000_0005, 1'b0);
        // the table bytes were overwritten; restore patterns cannot alias data pages
        wr(6'h08, 32'h3);

        // R3 R5 R6 R7: sweep start offsets near a page end and counts 1..8
        for (int s = 32'hFFA; s <= 32'hFFF; s++)
            for (int c = 1; c <= 8; c++)
                to_dev_run(s, c, "R3 sweep");

        // R4: same mapping stored big-endian
        big_endian = 1'b1;
        poke_entry(13'h100, 32'h0000_1ABC, 1'b1);
        poke_entry(13'h108, 32'h0000_0005, 1'b1);
        to_dev_run(32'hFFC, 8, "R4 big-endian");
        big_endian = 1'b0;
        poke_entry(13'h100, 32'h0000_1ABC, 1'b0);
        poke_entry(13'h108, 32'h0000_0005, 1'b0);

        // R8: device-to-memory inside one page
        wr(6'h08, 32'h1);
        wr(6'h18, 32'h10);
        wr(6'h10, 6);
        f0 = n_fetch; d0 = n_done;
        go(1'b1);
        wait_done(d0, "R8");
        @(negedge clk);
        g0 = n_src - 6;
        for (int i = 0; i < 6; i++)
            check("R8", "written byte", mem[13'h1010 + 13'(i)], 8'hA0 + 8'(g0 + i));
        check("R7", "single page fetch", n_fetch - f0, 1);
        rd(6'h10, v);
        check("R9", "count cleared after write run", v, 0);

        // R2: direction mismatch and run clear
        wr(6'h10, 5);
        for (int k = 0; k < 3; k++) begin
            logic [31:0] en;
            logic        tm;
            en = (k == 0) ? 32'h3 : (k == 1) ? 32'h1 : 32'h2;
            tm = (k == 0) ? 1'b1 : 1'b0;
            wr(6'h08, en);
            f0 = n_fetch; b0 = n_byteop; r0 = n_rej; d0 = n_done;
            go(tm);
            repeat (6) @(negedge clk);
            check("R2", "reject pulse", n_rej - r0, 1);
            check("R2", "no memory traffic", (n_fetch - f0) + (n_byteop - b0), 0);
            check("R2", "no done", n_done - d0, 0);
            rd(6'h10, v);
            check("R2", "count kept", v, 5);
        end

        // R10: zero count
        wr(6'h08, 32'h3);
        wr(6'h10, 0);
        f0 = n_fetch; b0 = n_byteop; d0 = n_done;
        go(1'b0);
        wait_done(d0, "R10");
        check("R10", "no memory traffic", (n_fetch - f0) + (n_byteop - b0), 0);

        // R11: clear run while the first byte is stalled at the device
        wr(6'h18, 32'h20);
        wr(6'h10, 100);
        sink_ready = 1'b0;
        g0 = n_got; d0 = n_done;
        go(1'b0);
        for (int t = 0; t < 200 && !dout_valid; t++) @(negedge clk);
        check("R8", "byte presented", dout_valid, 1);
        wr(6'h08, 32'h2);
        sink_ready = 1'b1;
        wait_done(d0, "R11");
        @(negedge clk);
        check("R11", "bytes before stop", n_got - g0, 1);
        check("R11", "stopped byte", got[10'(g0)], pat(phys_of(32'h20)));
        rd(6'h10, v);
        check("R11", "count left as programmed", v, 100);
        check("R11", "idle after stop", busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule